// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Serial Shifter

This block is an eight-stage shift register with one serial output. Its contents come in one of two ways. In load mode, a whole byte is copied from a parallel bus into the stages. In shift mode, the contents move one stage toward the output and a serial input fills the first stage. Only the last stage drives the serial output. For test, all stages are also visible on a read-only debug bus.

Two tick inputs together form the register's clock. The register steps on a rising edge of their OR. Holding either tick high therefore freezes the register, and holding either tick low lets the other act as the clock. The whole block runs on one system clock. The ticks are sampled there, and an edge on them becomes a one-cycle clock enable, so no logic sits in the clock path. An active-low clear empties every stage at once, whatever the other inputs are doing. Its release passes through a two-flop synchronizer, so leaving clear never produces a partial step.

Top module: `shf_gated_piso`

## Requirements
- R1: While `clr_n` is low, every stage reads 0. This takes effect as soon as `clr_n` falls, with no system clock edge needed, and it overrides the mode and tick inputs.
- R2: In load mode (`mode_shift` = 0), a step copies `par_in[i]` into stage i. Bit 0 is the first stage and bit 7 is the last. `ser_in` has no effect during a load.
- R3: In shift mode (`mode_shift` = 1), a step puts `ser_in` into stage 0 and moves each stage i-1 into stage i.
- R4: A step happens at a system clock edge where `tick_a | tick_b` is 1 and was 0 at the previous edge. At every other edge, all stages keep their values.
- R5: While either tick is held high, pulses on the other tick do not change the stages.
- R6: The two ticks are interchangeable. With `tick_a` held low, pulses on `tick_b` step the register exactly as `tick_a` pulses do.
- R7: For the first three system clock edges after `clr_n` rises, the stages stay at zero and tick activity is ignored.
- R8: `q_last` always equals the last stage. A bit shifted in at `ser_in` appears on `q_last` after eight shift steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous assert, synchronous release |
| mode_shift | input | 1 | 1 = shift mode, 0 = parallel load mode |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data; bit i goes to stage i |
| tick_a | input | 1 | Tick input, ORed with tick_b to form the step edge |
| tick_b | input | 1 | Tick input, interchangeable with tick_a |
| q_last | output | 1 | Last stage, the serial output |
| stage_dbg | output | 8 | Read-only view of all stages, bit 0 = first stage |

## Verification
The checker checks these rules on every system clock edge: zero contents under clear, quiet stages during the release window, exact load and shift results after a detected tick edge, and stable contents at all other edges. Those properties compute the tick edge themselves, so they cannot show that the inhibit and interchange rules work in practice. The bench's scenarios show those. One holds `tick_b` high while pulsing `tick_a`, another clocks from `tick_b` alone, and another raises the inhibit only while the clock tick is high. Only the bench shows that the clear acts between clock edges and that a serial bit reaches `q_last` after exactly eight shift steps.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int DEF_STAGES  = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } shf_mode_e;

    typedef struct packed {
        shf_mode_e mode;
        logic      ser;
        logic      step;
        logic      hold;
    } shf_ctrl_t;

    function automatic logic tick_level(input logic a, input logic b);
        return a | b;
    endfunction

endpackage

// File: rtl/shf_clr_sync.sv
module shf_clr_sync
    import shf_pkg::*;
#(
    parameter int DEPTH = SYNC_STAGES
) (
    input  logic clk,
    input  logic clr_n,
    output logic hold
);
    logic [DEPTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[DEPTH-2:0], 1'b1};
        end
    end

    assign hold = ~pipe_q[DEPTH-1];
endmodule

// File: rtl/shf_tick_edge.sv
module shf_tick_edge
    import shf_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic hold,
    input  logic tick_a,
    input  logic tick_b,
    output logic step
);
    logic level;
    logic level_q;

    assign level = tick_level(tick_a, tick_b);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            level_q <= 1'b1;
        end else if (hold) begin
            level_q <= 1'b1;
        end else begin
            level_q <= level;
        end
    end

    assign step = level & ~level_q & ~hold;
endmodule

// File: rtl/shf_stage_bank.sv
module shf_stage_bank
    import shf_pkg::*;
#(
    parameter int STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  shf_ctrl_t         ctrl,
    input  logic [STAGES-1:0] par,
    output logic [STAGES-1:0] stages
);
    logic [STAGES-1:0] nxt;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic from_prev;
        if (i == 0) begin : g_first
            assign from_prev = ctrl.ser;
        end else begin : g_rest
            assign from_prev = stages[i-1];
        end

        always_comb begin
            if (ctrl.mode == MODE_LOAD) begin
                nxt[i] = par[i];
            end else begin
                nxt[i] = from_prev;
            end
        end

        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                stages[i] <= 1'b0;
            end else if (ctrl.hold) begin
                stages[i] <= 1'b0;
            end else if (ctrl.step) begin
                stages[i] <= nxt[i];
            end
        end
    end
endmodule

// File: rtl/shf_gated_piso.sv
module shf_gated_piso
    import shf_pkg::*;
#(
    parameter int STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              mode_shift,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              q_last,
    output logic [STAGES-1:0] stage_dbg
);
    logic              hold;
    logic              step;
    shf_ctrl_t         ctrl;
    logic [STAGES-1:0] stages;

    shf_clr_sync #(.DEPTH(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .clr_n (clr_n),
        .hold  (hold)
    );

    shf_tick_edge u_edge (
        .clk    (clk),
        .clr_n  (clr_n),
        .hold   (hold),
        .tick_a (tick_a),
        .tick_b (tick_b),
        .step   (step)
    );

    always_comb begin
        ctrl.mode = shf_mode_e'(mode_shift);
        ctrl.ser  = ser_in;
        ctrl.step = step;
        ctrl.hold = hold;
    end

    shf_stage_bank #(.STAGES(STAGES)) u_bank (
        .clk    (clk),
        .clr_n  (clr_n),
        .ctrl   (ctrl),
        .par    (par_in),
        .stages (stages)
    );

    assign q_last    = stages[STAGES-1];
    assign stage_dbg = stages;
endmodule

// File: rtl/shf_gated_piso_chk.sv
module shf_gated_piso_chk
    import shf_pkg::*;
#(
    parameter int STAGES = DEF_STAGES
) (
    input logic              clk,
    input logic              clr_n,
    input logic              mode_shift,
    input logic              ser_in,
    input logic [STAGES-1:0] par_in,
    input logic              tick_a,
    input logic              tick_b,
    input logic [STAGES-1:0] stage_dbg
);
    localparam int QUIET = SYNC_STAGES + 1;

    logic [2:0] since_rel;
    logic       live;
    logic       lvl;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            since_rel <= '0;
        end else if (since_rel < 3'(QUIET)) begin
            since_rel <= since_rel + 3'd1;
        end
    end

    assign live = (since_rel >= 3'(QUIET));
    assign lvl  = tick_a | tick_b;

    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |-> stage_dbg == '0);

    a_r7_release_quiet: assert property (@(posedge clk) disable iff (!clr_n)
        (since_rel < 3'(QUIET)) |=> stage_dbg == '0);

    a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
        (live && !mode_shift && lvl && !$past(lvl)) |=> stage_dbg == $past(par_in));

    a_r3_shift: assert property (@(posedge clk) disable iff (!clr_n)
        (live && mode_shift && lvl && !$past(lvl))
        |=> stage_dbg == {$past(stage_dbg[STAGES-2:0]), $past(ser_in)});

    a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (live && !(lvl && !$past(lvl))) |=> $stable(stage_dbg));
endmodule

bind shf_gated_piso shf_gated_piso_chk #(.STAGES(STAGES)) chk_i (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode_shift (mode_shift),
    .ser_in     (ser_in),
    .par_in     (par_in),
    .tick_a     (tick_a),
    .tick_b     (tick_b),
    .stage_dbg  (stage_dbg)
);

// File: tb/shf_gated_piso_tb_top.sv
module shf_gated_piso_tb_top;
    localparam int N = 8;

    typedef struct {
        logic [N-1:0] stages;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         mode_shift = 1'b1;
    logic         ser_in = 1'b0;
    logic [N-1:0] par_in = '0;
    logic         tick_a = 1'b0;
    logic         tick_b = 1'b0;
    logic         q_last;
    logic [N-1:0] stage_dbg;

    int           n_run = 0;
    int           n_fail = 0;
    logic [N-1:0] model = '0;
    exp_t         exp_q[$];
    bit           done = 0;

    always #10 clk = ~clk;

    shf_gated_piso #(.STAGES(N)) dut_i (
        .clk(clk), .clr_n(clr_n), .mode_shift(mode_shift), .ser_in(ser_in),
        .par_in(par_in), .tick_a(tick_a), .tick_b(tick_b),
        .q_last(q_last), .stage_dbg(stage_dbg)
    );

    task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic push(string tag);
        exp_t e;
        e.stages = model;
        e.tag    = tag;
        exp_q.push_back(e);
    endtask

    // monitor: pops expected items as they are pushed and compares with outputs
    initial begin
        forever begin
            exp_t e;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            check(e.tag, stage_dbg, e.stages);
            check({e.tag, " q_last (R8)"}, {{(N-1){1'b0}}, q_last},
                  {{(N-1){1'b0}}, e.stages[N-1]});
        end
    end

    task automatic pulse_a();
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_b();
        @(negedge clk) tick_b = 1'b1;
        @(negedge clk) tick_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_load(logic [N-1:0] v, string tag);
        @(negedge clk);
        mode_shift = 1'b0; par_in = v; ser_in = 1'b1;
        pulse_a();
        model = v;
        push(tag);
    endtask

    task automatic do_shift(logic b, string tag);
        @(negedge clk);
        mode_shift = 1'b1; ser_in = b; par_in = ~model;
        pulse_a();
        model = {model[N-2:0], b};
        push(tag);
    endtask

    initial begin
        #1 clr_n = 1'b0;
        #2 check("R1 clear before any edge", stage_dbg, '0);
        repeat (3) @(negedge clk);
        check("R1 reset state", stage_dbg, '0);
        clr_n = 1'b1;
        repeat (5) @(negedge clk);

        do_load(8'hA5, "R2 load A5 with ser_in=1");
        do_load(8'h3C, "R2 load 3C");
        do_shift(1'b1, "R3 shift in 1");
        do_shift(1'b0, "R3 shift in 0");
        do_shift(1'b1, "R3 shift in 1 again");

        // R4: no tick edges, stages hold; tick_a held high also holds
        mode_shift = 1'b0; par_in = 8'hFF;
        repeat (4) @(negedge clk);
        push("R4 hold with ticks low");
        @(negedge clk) begin mode_shift = 1'b0; par_in = 8'h81; tick_a = 1'b1; end
        @(negedge clk);
        model = 8'h81;
        push("R4 single edge on rise");
        par_in = 8'h18;
        repeat (4) @(negedge clk);
        push("R4 tick_a held high holds");

        // R5: tick_b raised while tick_a is high, then tick_a pulses are ignored
        tick_b = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) tick_a = 1'b1;
            @(negedge clk) tick_a = 1'b0;
        end
        @(negedge clk);
        push("R5 inhibited by tick_b");
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_b = 1'b0;
        @(negedge clk) tick_a = 1'b0;
        @(negedge clk);
        push("R5 inhibit removed without step");

        // R6: tick_b acts as clock with tick_a low
        mode_shift = 1'b0; par_in = 8'h5A;
        pulse_b();
        model = 8'h5A;
        push("R6 load via tick_b");
        mode_shift = 1'b1; ser_in = 1'b1;
        pulse_b();
        model = {model[N-2:0], 1'b1};
        push("R6 shift via tick_b");

        // R8: a 1 reaches q_last after eight shifts
        do_load(8'h00, "R8 load zero");
        do_shift(1'b1, "R8 shift 1");
        for (int k = 0; k < 6; k++) do_shift(1'b0, "R8 shift 0");
        check("R8 q_last low after seven", {{(N-1){1'b0}}, q_last}, '0);
        do_shift(1'b0, "R8 eighth shift");
        check("R8 q_last high after eight", {{(N-1){1'b0}}, q_last}, 8'h01);

        // R1: clear between edges, overriding a pending load
        do_load(8'hF0, "R1 preload");
        @(negedge clk);
        mode_shift = 1'b0; par_in = 8'hFF;
        #3 clr_n = 1'b0;
        #1 check("R1 async clear mid-cycle", stage_dbg, '0);
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        check("R1 clear overrides tick", stage_dbg, '0);

        // R7: ticks ignored during release window
        @(negedge clk) begin clr_n = 1'b1; tick_a = 1'b1; end
        @(negedge clk) tick_a = 1'b0;
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        model = '0;
        push("R7 quiet after release");
        @(negedge clk);
        do_load(8'h42, "R7 normal after release");

        repeat (3) @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule